// File: doc/BRIEF.md
# Overlapping Multiphase Clock Generator

The block turns one fast master clock into a set of evenly spaced phase enables. All phases share the same period. Each phase is high for half of that period. Each phase starts a fixed fraction of the period after the one before it. A phase always rises while its predecessor is still high, so neighbouring phases overlap instead of sitting apart. The phases are registered enables in the master-clock domain. Logic that must cross phase boundaries without a register can gate its work with them.

The number of phases `NUM_PH` may be 3 to 6 and defaults to 4. One period lasts `2*NUM_PH` master ticks. Phase k rises at tick `2k` of the period and stays high for `NUM_PH` ticks. Some phases with higher numbers run past the end of the period and finish their pulse in the first ticks of the next one.

A run enable starts and stops the sequence. A per-period strobe marks each rising edge of phase 0. A sticky fault flag reports any phase rise that is not covered by its predecessor.

The control is a three-state machine:
- `MPG_IDLE`: all outputs are low.
- `MPG_RUN`: a period counter steps from 0 to `2*NUM_PH-1`.
- `MPG_DRAIN`: lets the pulses that run past the period end finish, for `NUM_PH-2` ticks.

The transitions are:
- `IDLE->RUN` when the enable is sampled high.
- `RUN->RUN` wrap, at the last tick of a period with the enable high.
- `RUN->DRAIN` at the last tick of a period with the enable low.
- `DRAIN->IDLE` when the last pulse tail ends.

Top module: `mpg_top`

## Requirements
- R1: While running, `start_o` is high for exactly one tick, in the same tick that `phase_o[0]` rises, and never at any other time.
- R2: Every pulse on every phase is high for exactly `NUM_PH` consecutive ticks, which is half the `2*NUM_PH`-tick period.
- R3: In every period, `phase_o[k]` rises exactly `2k` ticks after the strobe that opens that period.
- R4: Every rise of `phase_o[k]` happens while `phase_o[(k-1) mod NUM_PH]` is high. The one exception is the first rise of `phase_o[0]` after all phases were low.
- R5: A synchronous reset (`rst_i` high, active high) drives all phases, the strobe and the fault flag to 0 at the next clock edge.
- R6: While idle with `en_i` low, all phases and the strobe stay at 0.
- R7: The first output edge after the enable is sampled high appears one clock later. It is `phase_o[0]` with the strobe. The first period shows no fragment of a pulse from an earlier period.
- R8: When `en_i` is low at the last tick of a period, no new period starts. Pulses that run past the period end still complete, and then every output stays low.
- R9: `ovl_fault_o` is sticky until reset and stays 0 in legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable, sampled at each period end |
| phase_o | output | NUM_PH | Overlapping phase enables, bit k is phase k |
| start_o | output | 1 | One-tick strobe on each rise of phase 0 |
| ovl_fault_o | output | 1 | Sticky flag for a phase rise without its predecessor high |

## Verification
A wrong period counter value shows up at once as a phase vector with the wrong pattern. The ports reveal it within one tick, and the bench compares the whole vector against its model every tick. A wrong state shows up within a period. A stuck `MPG_RUN` keeps the phases toggling after the enable drops. A `MPG_DRAIN` that is skipped or too long cuts a tail short or stretches it, and the pulse-length check catches both. A wrong first-period marker shows as a fragment of an earlier pulse at start, or as a raised fault flag.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
    typedef enum logic [1:0] {
        MPG_IDLE  = 2'd0,
        MPG_RUN   = 2'd1,
        MPG_DRAIN = 2'd2
    } mpg_state_e;
endpackage

// File: rtl/mpg_seq.sv
module mpg_seq
    import mpg_pkg::*;
#(
    parameter int NP = 4,
    parameter int CW = $clog2(2 * NP)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    output mpg_state_e    state_o,
    output logic [CW-1:0] cnt_o,
    output logic          first_o
);
    localparam logic [CW-1:0] PER_LAST  = CW'(2 * NP - 1);
    localparam logic [CW-1:0] TAIL_LAST = CW'(NP - 3);

    mpg_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          first_q, first_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= MPG_IDLE;
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            first_q <= first_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        first_d = first_q;
        unique case (state_q)
            MPG_IDLE: begin
                if (en_i) begin
                    state_d = MPG_RUN;
                    cnt_d   = '0;
                    first_d = 1'b1;
                end
            end
            MPG_RUN: begin
                if (cnt_q == PER_LAST) begin
                    cnt_d   = '0;
                    first_d = 1'b0;
                    state_d = en_i ? MPG_RUN : MPG_DRAIN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            MPG_DRAIN: begin
                if (cnt_q == TAIL_LAST) begin
                    state_d = MPG_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = MPG_IDLE;
                cnt_d   = '0;
                first_d = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
    assign first_o = first_q;
endmodule

// File: rtl/mpg_decode.sv
module mpg_decode
    import mpg_pkg::*;
#(
    parameter int NP = 4,
    parameter int CW = $clog2(2 * NP)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  mpg_state_e    state_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          first_i,
    output logic [NP-1:0] ph_d_o,
    output logic [NP-1:0] ph_q_o,
    output logic          start_q_o
);
    logic [NP-1:0] ph_d;
    logic          start_d;

    always_comb begin
        ph_d = '0;
        for (int k = 0; k < NP; k++) begin
            int c;
            int d;
            c = int'(cnt_i);
            d = (c >= 2 * k) ? (c - 2 * k) : (c + 2 * NP - 2 * k);
            unique case (state_i)
                MPG_RUN:   ph_d[k] = (d < NP) && !(first_i && (c < 2 * k));
                MPG_DRAIN: ph_d[k] = (c + 2 * NP) < (2 * k + NP);
                default:   ph_d[k] = 1'b0;
            endcase
        end
        start_d = (state_i == MPG_RUN) && (cnt_i == '0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q_o    <= '0;
            start_q_o <= 1'b0;
        end else begin
            ph_q_o    <= ph_d;
            start_q_o <= start_d;
        end
    end

    assign ph_d_o = ph_d;
endmodule

// File: rtl/mpg_ovl_mon.sv
module mpg_ovl_mon #(
    parameter int NP = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [NP-1:0] ph_d_i,
    input  logic [NP-1:0] ph_q_i,
    input  logic          first_i,
    output logic          fault_o
);
    logic bad;

    always_comb begin
        bad = 1'b0;
        for (int k = 0; k < NP; k++) begin
            if (ph_d_i[k] && !ph_q_i[k] && !ph_d_i[(k + NP - 1) % NP]
                && !(k == 0 && first_i)) begin
                bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) fault_o <= 1'b0;
        else       fault_o <= fault_o | bad;
    end
endmodule

// File: rtl/mpg_top.sv
module mpg_top
    import mpg_pkg::*;
#(
    parameter int NUM_PH = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    output logic [NUM_PH-1:0] phase_o,
    output logic              start_o,
    output logic              ovl_fault_o
);
    localparam int CW = $clog2(2 * NUM_PH);

    if (NUM_PH < 3 || NUM_PH > 6) begin : g_bad_np
        $error("mpg_top: NUM_PH must lie in 3..6");
    end

    mpg_state_e        state;
    logic [CW-1:0]     cnt;
    logic              first;
    logic [NUM_PH-1:0] ph_d;

    mpg_seq #(.NP(NUM_PH), .CW(CW)) u_seq (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .state_o (state),
        .cnt_o   (cnt),
        .first_o (first)
    );

    mpg_decode #(.NP(NUM_PH), .CW(CW)) u_dec (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .state_i   (state),
        .cnt_i     (cnt),
        .first_i   (first),
        .ph_d_o    (ph_d),
        .ph_q_o    (phase_o),
        .start_q_o (start_o)
    );

    mpg_ovl_mon #(.NP(NUM_PH)) u_mon (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ph_d_i  (ph_d),
        .ph_q_i  (phase_o),
        .first_i (first),
        .fault_o (ovl_fault_o)
    );
endmodule

// File: rtl/mpg_checker.sv
module mpg_checker #(
    parameter int NP = 4
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic [NP-1:0] phase_o,
    input logic          start_o,
    input logic          ovl_fault_o
);
    logic [7:0] hi_len [NP];

    always_ff @(posedge clk_i) begin
        for (int k = 0; k < NP; k++) begin
            if (rst_i || !phase_o[k]) hi_len[k] <= '0;
            else                      hi_len[k] <= hi_len[k] + 8'd1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (phase_o == '0 && !start_o && !ovl_fault_o)); // R5

    AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        start_o |=> !start_o); // R1

    AST_STROBE_ON_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        start_o |-> (phase_o[0] && !$past(phase_o[0]))); // R1

    AST_NO_FAULT: assert property (@(posedge clk_i) disable iff (rst_i)
        !ovl_fault_o); // R9

    for (genvar k = 0; k < NP; k++) begin : g_chk
        AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
            ($fell(phase_o[k]) && !$past(rst_i)) |-> (hi_len[k] == 8'(NP))); // R2

        AST_PULSE_MAX: assert property (@(posedge clk_i) disable iff (rst_i)
            hi_len[k] <= 8'(NP)); // R2

        if (k > 0) begin : g_pred
            AST_PRED_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
                $rose(phase_o[k]) |-> phase_o[k-1]); // R4
        end
    end
endmodule

bind mpg_top mpg_checker #(.NP(NUM_PH)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .phase_o     (phase_o),
    .start_o     (start_o),
    .ovl_fault_o (ovl_fault_o)
);

// File: tb/mpg_top_tb_top.sv
module mpg_top_tb_top;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [NP-1:0] ph;
    logic          st;
    logic          flt;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    mpg_top #(.NUM_PH(NP)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .en_i        (en),
        .phase_o     (ph),
        .start_o     (st),
        .ovl_fault_o (flt)
    );

    // Reference model: mode 0 idle, 1 run, 2 drain; tick is position in period
    int            m_mode = 0;
    int            m_tick = 0;
    bit            m_first = 1'b0;
    logic [NP-1:0] exp_ph = '0;
    logic          exp_st = 1'b0;
    string         exp_tag = "R5";

    function automatic logic [NP-1:0] ref_phases(int mode, int t, bit first);
        logic [NP-1:0] v = '0;
        for (int k = 0; k < NP; k++) begin
            int rel = (t - 2 * k + 2 * NP) % (2 * NP);
            if (mode == 1)      v[k] = (rel < NP) && !(first && t < 2 * k);
            else if (mode == 2) v[k] = (t + 2 * NP) < (2 * k + NP);
        end
        return v;
    endfunction

    function automatic string ref_tag(int mode, bit first);
        if (mode == 0) return "R6";
        if (mode == 2) return "R8";
        return first ? "R7" : "R3";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode <= 0; m_tick <= 0; m_first <= 1'b0;
            exp_ph <= '0; exp_st <= 1'b0; exp_tag <= "R5";
        end else begin
            exp_ph  <= ref_phases(m_mode, m_tick, m_first);
            exp_st  <= (m_mode == 1) && (m_tick == 0);
            exp_tag <= ref_tag(m_mode, m_first);
            if (m_mode == 0) begin
                if (en) begin m_mode <= 1; m_tick <= 0; m_first <= 1'b1; end
            end else if (m_mode == 1) begin
                if (m_tick == 2 * NP - 1) begin
                    m_tick <= 0; m_first <= 1'b0;
                    m_mode <= en ? 1 : 2;
                end else m_tick <= m_tick + 1;
            end else begin
                if (m_tick == NP - 3) begin m_mode <= 0; m_tick <= 0; end
                else m_tick <= m_tick + 1;
            end
        end
    end

    // Observation side
    logic [NP-1:0] prev_ph = '0;
    int            run_len [NP];
    bit            len_ok  [NP];
    int            last_st = 0;
    bit            st_ok   = 1'b0;

    always @(negedge clk) begin
        cyc++;
        checks++;
        if (ph !== exp_ph) begin
            fails++;
            $display("FAIL %s phases act=%b exp=%b cyc=%0d", exp_tag, ph, exp_ph, cyc);
        end
        checks++;
        if (st !== exp_st) begin
            fails++;
            $display("FAIL R1 strobe act=%b exp=%b cyc=%0d", st, exp_st, cyc);
        end
        checks++;
        if (flt !== 1'b0) begin
            fails++;
            $display("FAIL R9 fault flag act=%b exp=0 cyc=%0d", flt, cyc);
        end
        if (rst) begin
            st_ok = 1'b0;
            for (int k = 0; k < NP; k++) begin run_len[k] = 0; len_ok[k] = 1'b0; end
        end else begin
            if (st) begin last_st = cyc; st_ok = 1'b1; end
            for (int k = 0; k < NP; k++) begin
                if (ph[k] && !prev_ph[k]) begin
                    run_len[k] = 1; len_ok[k] = 1'b1;
                    // R4: predecessor covers the rise, unless starting from all-low
                    if (!(k == 0 && prev_ph == '0)) begin
                        checks++;
                        if (!ph[(k + NP - 1) % NP]) begin
                            fails++;
                            $display("FAIL R4 rise of phase %0d act=pred_low exp=pred_high", k);
                        end
                    end
                    // R3: spacing from the period strobe
                    if (st_ok) begin
                        checks++;
                        if (cyc - last_st != 2 * k) begin
                            fails++;
                            $display("FAIL R3 phase %0d offset act=%0d exp=%0d",
                                     k, cyc - last_st, 2 * k);
                        end
                    end
                end else if (ph[k]) begin
                    run_len[k]++;
                end else if (prev_ph[k] && len_ok[k]) begin
                    checks++;
                    if (run_len[k] != NP) begin
                        fails++;
                        $display("FAIL R2 phase %0d width act=%0d exp=%0d", k, run_len[k], NP);
                    end
                end
            end
        end
        prev_ph = ph;
    end

    task automatic hold(input bit e, input int n);
        @(negedge clk);
        en <= e;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240613));
        repeat (3) @(negedge clk);
        rst <= 1'b0;
        hold(1'b0, 10);               // R6 idle stays low
        hold(1'b1, 3 * 2 * NP + 2);   // R7 start, steady R2 R3
        hold(1'b0, 4 * NP);           // R8 drain and stop
        hold(1'b1, 2);                // one-period run then stop
        hold(1'b0, 3 * NP);
        for (int i = 0; i < 80; i++) begin
            if (i == 40) begin
                @(negedge clk); rst <= 1'b1;   // R5 mid-run reset
                repeat (2) @(negedge clk); rst <= 1'b0;
            end
            hold(1'($urandom_range(0, 1)), int'($urandom_range(1, 30)));
        end
        hold(1'b0, 4 * NP);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule